// File: doc/BRIEF.md
# Multichannel ADC Scan Sequencer

This block runs one scan of sixteen analog inputs through an external analog multiplexer and a successive-approximation converter. It sits idle with every output low until it sees a rising edge on its start input. It then works through the channels one at a time. For each channel it drives the multiplexer select, pulses the converter's start-of-conversion line, waits out the conversion time and raises a strobe. On the strobe it captures the converter's parallel result into an output register.

Each channel gets a fixed 200 µs slot. The slot opens with a 100 µs settling wait. SOC is then high for 2 µs, followed by a 40 µs conversion wait and a 2 µs strobe. After the strobe come a short hold and the select increment, and the rest of the slot is padding. All times are counted in microsecond ticks, made by a prescaler from the system clock. The prescaler restarts with every accepted start, so each edge falls an exact number of clock cycles after the start edge. When the last slot ends, the block returns to idle and pulses a done flag for one cycle.

Top module: `adc_scan_seq`

## Requirements
- R1: After synchronous reset, ch_sel is 0 and adc_soc, adc_strobe, scan_done and sample_data are all 0.
- R2: While idle, all outputs stay at their reset values until start is sampled high after being sampled low.
- R3: With P = CLK_PER_US clock cycles per microsecond and k the number of clock edges since the edge that accepted start, adc_soc is high exactly for 100P + 200P·s <= k < 102P + 200P·s, for each slot s = 0..15.
- R4: adc_strobe is high exactly for 142P + 200P·s <= k < 144P + 200P·s, and is never high together with adc_soc.
- R5: sample_data loads adc_data on the clock edge where adc_strobe rises, and it holds its value at all other times.
- R6: ch_sel is s during the first 146P cycles of slot s, then becomes (s+1) mod 16, so the channels are visited 0 to 15 in ascending order.
- R7: At k = 3200P the block is idle again with ch_sel = 0, and scan_done is high for that single cycle only.
- R8: A start rising edge that is sampled on any edge before the block is idle has no effect, including the edge where k = 3200P. A rising edge sampled one edge later starts a new scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Scan request; acted on at a rising edge |
| adc_data | input | DATA_W | Converter parallel result |
| ch_sel | output | SEL_W | Multiplexer channel select |
| adc_soc | output | 1 | Start-of-conversion pulse |
| adc_strobe | output | 1 | Data latch strobe |
| sample_data | output | DATA_W | Last captured conversion result |
| scan_done | output | 1 | One-cycle pulse at end of scan |

## Verification
Two functions can meet on a single clock edge: completion of the scan, and detection of a start edge. A start rise is placed exactly on the completing edge, where it must be dropped. Another is placed one edge later, where it must launch a new scan. The bench checks both outcomes through the SOC pulse count and the select value. Random start pulses in the middle of a scan and random converter data at every cycle are compared against a cycle-indexed timing model.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LEAD = 3'd1,
    ST_SOC  = 3'd2,
    ST_CONV = 3'd3,
    ST_STB  = 3'd4,
    ST_HOLD = 3'd5,
    ST_NEXT = 3'd6
  } seq_state_e;
endpackage

// File: rtl/us_tick_gen.sv
module us_tick_gen #(
  parameter int CLK_PER_US = 100,
  parameter int PRE_W      = $clog2(CLK_PER_US + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam logic [PRE_W-1:0] LAST = PRE_W'(CLK_PER_US - 1);

  logic [PRE_W-1:0] pre_cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)        pre_cnt <= '0;
    else if (pre_cnt == LAST) pre_cnt <= '0;
    else                    pre_cnt <= pre_cnt + 1'b1;
  end

  assign tick = run && (pre_cnt == LAST);

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R3
endmodule

// File: rtl/start_edge.sv
module start_edge (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic rise
);
  logic start_q;

  always_ff @(posedge clk) begin
    if (rst) start_q <= 1'b0;
    else     start_q <= start;
  end

  assign rise = start && !start_q;
endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  logic [CNT_W-1:0] us_cnt;

  assign expire = tick && (us_cnt == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || clear || expire) us_cnt <= '0;
    else if (tick)              us_cnt <= us_cnt + 1'b1;
  end

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (rst)
    us_cnt < limit); // R6
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_seq_pkg::*;
#(
  parameter int CLK_PER_US = 100,
  parameter int NUM_CH     = 16,
  parameter int DATA_W     = 8,
  parameter int SEL_W      = $clog2(NUM_CH),
  parameter int LEAD_US    = 100,
  parameter int SOC_US     = 2,
  parameter int CONV_US    = 40,
  parameter int STB_US     = 2,
  parameter int HOLD_US    = 2,
  parameter int SLOT_US    = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] adc_data,
  output logic [SEL_W-1:0]  ch_sel,
  output logic              adc_soc,
  output logic              adc_strobe,
  output logic [DATA_W-1:0] sample_data,
  output logic              scan_done
);
  localparam int NEXT_US = SLOT_US - LEAD_US - SOC_US - CONV_US - STB_US - HOLD_US;
  localparam int CNT_W   = $clog2(SLOT_US + 1);
  localparam logic [SEL_W-1:0] LAST_CH = SEL_W'(NUM_CH - 1);

  seq_state_e       state, nxt;
  logic             rise, tick, expire;
  logic [CNT_W-1:0] limit;

  start_edge u_edge (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .rise  (rise)
  );

  us_tick_gen #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (state != ST_IDLE),
    .tick (tick)
  );

  phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clear  (state == ST_IDLE),
    .tick   (tick),
    .limit  (limit),
    .expire (expire)
  );

  always_comb begin
    case (state)
      ST_LEAD: limit = CNT_W'(LEAD_US);
      ST_SOC:  limit = CNT_W'(SOC_US);
      ST_CONV: limit = CNT_W'(CONV_US);
      ST_STB:  limit = CNT_W'(STB_US);
      ST_HOLD: limit = CNT_W'(HOLD_US);
      ST_NEXT: limit = CNT_W'(NEXT_US);
      default: limit = CNT_W'(1);
    endcase
  end

  always_comb begin
    case (state)
      ST_IDLE: nxt = ST_LEAD;
      ST_LEAD: nxt = ST_SOC;
      ST_SOC:  nxt = ST_CONV;
      ST_CONV: nxt = ST_STB;
      ST_STB:  nxt = ST_HOLD;
      ST_HOLD: nxt = ST_NEXT;
      ST_NEXT: nxt = (ch_sel == '0) ? ST_IDLE : ST_LEAD;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      ch_sel      <= '0;
      adc_soc     <= 1'b0;
      adc_strobe  <= 1'b0;
      sample_data <= '0;
      scan_done   <= 1'b0;
    end else begin
      scan_done <= 1'b0;
      if (state == ST_IDLE) begin
        ch_sel <= '0;
        if (rise) state <= ST_LEAD;
      end else if (expire) begin
        state      <= nxt;
        adc_soc    <= (nxt == ST_SOC);
        adc_strobe <= (nxt == ST_STB);
        if (nxt == ST_STB)  sample_data <= adc_data;
        if (nxt == ST_NEXT) ch_sel <= (ch_sel == LAST_CH) ? '0 : ch_sel + 1'b1;
        if (nxt == ST_IDLE) scan_done <= 1'b1;
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> (!adc_soc && !adc_strobe)); // R2
  AST_SOC_STB_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(adc_soc && adc_strobe)); // R4
  AST_SOC_WIDE: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_soc) |=> adc_soc); // R3
  AST_DATA_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    !$stable(sample_data) |-> $rose(adc_strobe)); // R5
  AST_SEL_STEP: assert property (@(posedge clk) disable iff (rst)
    (ch_sel != $past(ch_sel)) |-> (ch_sel == (($past(ch_sel) == LAST_CH) ? '0 : $past(ch_sel) + 1'b1))); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    scan_done |=> !scan_done); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    scan_done |-> (ch_sel == '0 && state == ST_IDLE)); // R7
endmodule

// File: tb/adc_scan_seq_bench.sv
module adc_scan_seq_bench;
  localparam int P    = 3;
  localparam int SLOT = 200 * P;
  localparam int SCAN = 16 * SLOT;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] adc_data = 8'h00;
  logic [3:0] ch_sel;
  logic       adc_soc, adc_strobe, scan_done;
  logic [7:0] sample_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  bit         act = 0;
  int         k = 0;
  bit         start_prev = 0;
  logic [7:0] exp_data = 8'h00;
  int         soc_rises = 0;
  logic       soc_prev = 1'b0;

  always #5 clk = ~clk;

  adc_scan_seq #(.CLK_PER_US(P)) u_adc_scan_seq (
    .clk(clk), .rst(rst), .start(start), .adc_data(adc_data),
    .ch_sel(ch_sel), .adc_soc(adc_soc), .adc_strobe(adc_strobe),
    .sample_data(sample_data), .scan_done(scan_done)
  );

  task automatic chk(input string req, input string what, input int actual, input int expect_v);
    total++;
    if (actual != expect_v) begin
      bad++;
      if (bad < 30) $display("FAIL %s %s actual=%0d expected=%0d (k=%0d)", req, what, actual, expect_v, k);
    end
  endtask

  function automatic int exp_soc();
    int r = k % SLOT;
    if (!act || k >= SCAN) return 0;
    return (r >= 100*P && r < 102*P) ? 1 : 0;
  endfunction

  function automatic int exp_stb();
    int r = k % SLOT;
    if (!act || k >= SCAN) return 0;
    return (r >= 142*P && r < 144*P) ? 1 : 0;
  endfunction

  function automatic int exp_sel();
    if (!act || k >= SCAN) return 0;
    return ((k / SLOT) + (((k % SLOT) >= 146*P) ? 1 : 0)) % 16;
  endfunction

  task automatic step(input bit st);
    bit fsm_idle;
    @(negedge clk);
    if (adc_soc && !soc_prev) soc_rises++;
    soc_prev = adc_soc;
    chk("R3", "soc", int'(adc_soc), exp_soc());
    chk("R4", "strobe", int'(adc_strobe), exp_stb());
    chk("R5", "data", int'(sample_data), int'(exp_data));
    chk("R6", "sel", int'(ch_sel), exp_sel());
    chk("R7", "done", int'(scan_done), (act && k == SCAN) ? 1 : 0);
    start = st;
    adc_data = 8'($urandom);
    if (act && k < SCAN && ((k + 1) % SLOT) == 142*P) exp_data = adc_data;
    fsm_idle = !act || (k == SCAN);
    if (fsm_idle && st && !start_prev) begin
      act = 1; k = 0;
    end else if (act && k < SCAN) k++;
    else act = 0;
    start_prev = st;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int base;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "reset sel", int'(ch_sel), 0);
    chk("R1", "reset soc/strobe/done", int'({adc_soc, adc_strobe, scan_done}), 0);
    chk("R1", "reset data", int'(sample_data), 0);

    // R2: no edge, no activity
    repeat (300) step(1'b0);
    chk("R2", "idle soc rises", soc_rises, 0);

    // plain scan
    base = soc_rises;
    step(1'b1);
    while (act) step(1'b0);
    chk("R7", "soc pulses per scan", soc_rises - base, 16);

    // R8: random start pulses during the scan are ignored
    base = soc_rises;
    step(1'b0);
    step(1'b1);
    while (act) step((($urandom % 8) == 0) && k < SCAN - 2);
    chk("R8", "soc pulses with mid-scan starts", soc_rises - base, 16);

    // R8: start rise on the completing edge is dropped
    base = soc_rises;
    step(1'b0);
    step(1'b1);
    while (!(act && k == SCAN - 1)) step(1'b0);
    step(1'b1);
    repeat (5) step(1'b1);
    repeat (150 * P) step(1'b0);
    chk("R8", "rise on final edge ignored", soc_rises - base, 16);
    chk("R8", "sel idle after ignored rise", int'(ch_sel), 0);

    // R8: rise one edge after completion launches a new scan
    base = soc_rises;
    step(1'b1);
    while (!(act && k == SCAN)) step(1'b0);
    step(1'b1);
    while (act) step(1'b0);
    repeat (10) step(1'b0);
    chk("R8", "back-to-back scans", soc_rises - base, 32);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule